// File: doc/BRIEF.md
# Restartable Burst Read Prefetch Pipeline

This block feeds a 32-bit local-bus slave read port from one of several per-channel output FIFOs. A bridge on that port pulls data out in bursts. Once the block is enabled, the first read access to its data address starts a prefetch engine. The engine pops words from the selected FIFO and passes them through a chain of registered stages: a fetch register, an input register and a holding register. The holding register drives the read data bus. Ready is held off until the holding register has a word. After that the holding register advances on every clock while the bridge keeps reading.

A burst ends on a beat that carries the active-low burst-last strobe. Words that are already in the pipeline stay there. The next burst therefore gets its first word in its first cycle, with no refill delay. A change of channel or a cleared enable flushes the pipeline, so a word from one channel is never handed out for another. A burst is never granted more than a fixed number of clocks.

Bus convention: `bus_sel` is high for the whole of a read access to the data address and low between accesses. A beat completes on a rising edge where `bus_sel` and `rd_ready` are both high. `blast_n` low during a completed beat marks that beat as the last one of the burst. FIFO words are show-ahead: `fifo_data` is valid whenever the matching `fifo_empty` bit is low, and a one-cycle `fifo_rd` pulse removes that word.

Top module: `burst_prefetch_pipe`

## Requirements
- R1: After reset all stages are empty, `rd_ready` is low and no FIFO is popped until a read access starts the engine.
- R2: While `cfg_en` is low, read accesses are ignored: `fifo_rd` stays all zero and `rd_ready` stays low.
- R3: With the pipeline empty, a read access first presented in cycle 0 (with `cfg_en` high and the channel unchanged) gets `rd_ready` high first in cycle NSTAGE+1 (cycle 4 with three stages), and in no earlier cycle.
- R4: Words are returned in FIFO order, one per completed beat. While the selected FIFO has data, `rd_ready` stays high on every cycle of the burst. With the defaults, the word from channel c numbered n reads as c in bits 31:24 and n in bits 23:0 of the bench's FIFO model.
- R5: After a completed beat with `blast_n` low, `rd_ready` stays low until `bus_sel` has gone low.
- R6: Words held in the pipeline when a burst ends are kept. The next access sees `rd_ready` in its first cycle and gets the next word in sequence, with no gap and no repeat.
- R7: If the selected FIFO runs empty during a burst, `rd_ready` drops for the beats that have no word. Reads resume NSTAGE cycles after data reappears, with no word lost.
- R8: Only the selected channel's FIFO is popped, with at most one `fifo_rd` bit high per cycle. Returned data comes from that channel.
- R9: A change of `cfg_chan` or a low `cfg_enable` flushes every stage. `rd_ready` is low in the cycle of the change. The next access has the cold-start latency, plus one cycle if the change happens in its first cycle.
- R10: Counted from the first cycle of an access, `rd_ready` is never high once MAX_BURST clocks of that access have passed. A warm burst with data available without pause returns exactly MAX_BURST words.
- R11: Once started, the engine keeps popping with no bus activity until all NSTAGE stages are full. After an access of k beats, the FIFO has been popped k+NSTAGE times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enables the prefetch engine |
| cfg_chan | input | CHW | Selects the source FIFO |
| fifo_empty | input | NCH | Per-channel empty flags |
| fifo_data | input | NCH*DW | Per-channel show-ahead words, channel c at bits c*DW upward |
| fifo_rd | output | NCH | Per-channel pop strobes |
| bus_sel | input | 1 | Read access to the data address in progress |
| blast_n | input | 1 | Active-low last-beat strobe |
| rd_ready | output | 1 | Beat ready; data valid |
| rd_data | output | DW | Holding register contents |

## Verification
`rd_ready` is a combinational function of `bus_sel` and registered state. The bench therefore drives every input just after a falling edge and samples one time unit later, in the same cycle the beat completes. Cold-start ready is due NSTAGE+1 cycles after the access is presented. A refill after an empty FIFO brings ready back NSTAGE cycles after data appears. A channel change inside an access adds one cycle, and the effect of burst-last is seen on the cycle after the marked beat. The bench indexes every access by cycle and compares the cycle of the first ready, the count of ready-low cycles after it and the number of beats against these figures. It tracks pop counts through its own FIFO model.

// File: rtl/burst_prefetch_pkg.sv
package burst_prefetch_pkg;

   typedef enum logic [1:0] {
      BG_IDLE,
      BG_RUN,
      BG_DONE
   } burst_phase_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bp_chan_mux.sv
module bp_chan_mux #(
   parameter int NCH = 4,
   parameter int DW  = 32,
   parameter int CHW = 2
) (
   input  logic [CHW-1:0]    sel,
   input  logic [NCH*DW-1:0] fifo_data,
   input  logic [NCH-1:0]    fifo_empty,
   input  logic              pop,
   output logic [NCH-1:0]    fifo_rd,
   output logic              sel_empty,
   output logic [DW-1:0]     sel_data
);

   logic [NCH-1:0] hit;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign hit[c]     = (sel == CHW'(c));
      assign fifo_rd[c] = pop & hit[c];
   end

   always_comb begin
      sel_data = '0;
      for (int c = 0; c < NCH; c++) begin
         if (hit[c]) sel_data = sel_data | fifo_data[c*DW +: DW];
      end
   end

   // a select beyond NCH matches nothing and reads as empty
   assign sel_empty = ~|(hit & ~fifo_empty);

endmodule

// File: rtl/bp_stage.sv
module bp_stage #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          load,
   input  logic          unload,
   input  logic [DW-1:0] d,
   output logic          v,
   output logic [DW-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v <= 1'b0;
         q <= '0;
      end else if (flush) begin
         v <= 1'b0;
      end else if (load) begin
         v <= 1'b1;
         q <= d;
      end else if (unload) begin
         v <= 1'b0;
      end
   end

endmodule

// File: rtl/bp_burst_guard.sv
module bp_burst_guard
   import burst_prefetch_pkg::*;
#(
   parameter int MAX_BURST = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_sel,
   input  logic beat,
   input  logic last_n,
   output logic ok
);

   localparam int CW = $clog2(MAX_BURST + 1);

   burst_phase_e    phase;
   logic [CW-1:0]   clk_cnt;

   assign ok = bus_sel && (phase != BG_DONE) && (clk_cnt < CW'(MAX_BURST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= BG_IDLE;
         clk_cnt <= '0;
      end else if (!bus_sel) begin
         phase   <= BG_IDLE;
         clk_cnt <= '0;
      end else if (beat && !last_n) begin
         phase   <= BG_DONE;
      end else if (phase != BG_DONE) begin
         phase   <= BG_RUN;
         if (clk_cnt < CW'(MAX_BURST)) clk_cnt <= clk_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/burst_prefetch_pipe.sv
module burst_prefetch_pipe
   import burst_prefetch_pkg::*;
#(
   parameter int NCH       = 4,
   parameter int DW        = 32,
   parameter int NSTAGE    = 3,
   parameter int MAX_BURST = 256,
   localparam int CHW      = idx_width(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [CHW-1:0]    cfg_chan,
   input  logic [NCH-1:0]    fifo_empty,
   input  logic [NCH*DW-1:0] fifo_data,
   output logic [NCH-1:0]    fifo_rd,
   input  logic              bus_sel,
   input  logic              blast_n,
   output logic              rd_ready,
   output logic [DW-1:0]     rd_data
);

   if (NSTAGE < 2) begin : g_bad_depth
      $error("burst_prefetch_pipe: NSTAGE must be at least 2");
   end
   if (NCH < 1 || DW < 1) begin : g_bad_width
      $error("burst_prefetch_pipe: NCH and DW must be positive");
   end
   if (MAX_BURST < 1) begin : g_bad_limit
      $error("burst_prefetch_pipe: MAX_BURST must be positive");
   end

   logic [CHW-1:0]  chan_q;
   logic            engine_on;
   logic            flush;
   logic            sel_empty;
   logic [DW-1:0]   sel_data;
   logic            src_ok;
   logic            beat;
   logic            guard_ok;
   logic [NSTAGE-1:0] st_v;
   logic [NSTAGE-1:0] src_v;
   logic [NSTAGE:0]   mv;
   logic [DW-1:0]     st_q [NSTAGE];
   logic [DW-1:0]     st_d [NSTAGE];

   assign flush = !cfg_en || (cfg_chan != chan_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_q    <= '0;
         engine_on <= 1'b0;
      end else begin
         chan_q <= cfg_chan;
         if (flush)        engine_on <= 1'b0;
         else if (bus_sel) engine_on <= 1'b1;
      end
   end

   bp_chan_mux #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_mux (
      .sel        (chan_q),
      .fifo_data  (fifo_data),
      .fifo_empty (fifo_empty),
      .pop        (mv[0]),
      .fifo_rd    (fifo_rd),
      .sel_empty  (sel_empty),
      .sel_data   (sel_data)
   );

   assign src_ok = engine_on && !sel_empty && !flush;
   assign src_v  = {st_v[NSTAGE-2:0], src_ok};

   // a word enters stage i when its source holds one and stage i is free or emptying
   always_comb begin
      mv[NSTAGE] = beat;
      for (int i = NSTAGE - 1; i >= 0; i--) begin
         mv[i] = src_v[i] && (!st_v[i] || mv[i+1]);
      end
   end

   for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
      if (i == 0) begin : g_head
         assign st_d[i] = sel_data;
      end else begin : g_body
         assign st_d[i] = st_q[i-1];
      end
      bp_stage #(.DW(DW)) u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .flush  (flush),
         .load   (mv[i]),
         .unload (mv[i+1]),
         .d      (st_d[i]),
         .v      (st_v[i]),
         .q      (st_q[i])
      );
   end

   bp_burst_guard #(.MAX_BURST(MAX_BURST)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_sel (bus_sel),
      .beat    (beat),
      .last_n  (blast_n),
      .ok      (guard_ok)
   );

   assign rd_ready = bus_sel && st_v[NSTAGE-1] && !flush && guard_ok;
   assign beat     = rd_ready;
   assign rd_data  = st_q[NSTAGE-1];

endmodule

// File: rtl/burst_prefetch_chk.sv
module burst_prefetch_chk #(
   parameter int NCH       = 4,
   parameter int CHW       = 2,
   parameter int MAX_BURST = 256
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cfg_en,
   input logic [CHW-1:0] cfg_chan,
   input logic [NCH-1:0] fifo_rd,
   input logic           bus_sel,
   input logic           blast_n,
   input logic           rd_ready,
   input logic           last_v
);

   localparam int CW = $clog2(MAX_BURST + 1);

   logic [CW-1:0]  run_cnt;
   logic [NCH-1:0] sel_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          run_cnt <= '0;
      else if (!bus_sel)                   run_cnt <= '0;
      else if (run_cnt < CW'(MAX_BURST))   run_cnt <= run_cnt + 1'b1;
   end

   always_comb begin
      sel_mask = '0;
      for (int c = 0; c < NCH; c++) sel_mask[c] = (cfg_chan == CHW'(c));
   end

   a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !rd_ready);

   a_r2_no_pop_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |-> (fifo_rd == '0));

   a_r2_no_ready_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |-> !rd_ready);

   a_r4_ready_has_word: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready |-> last_v);

   a_r5_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && rd_ready && !blast_n) |=> !rd_ready);

   a_r8_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fifo_rd));

   a_r8_pop_selected: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_rd & ~sel_mask) == '0);

   a_r9_flush_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_chan != $past(cfg_chan)) |-> !rd_ready);

   a_r10_burst_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt >= CW'(MAX_BURST)) |-> !rd_ready);

endmodule

bind burst_prefetch_pipe burst_prefetch_chk #(
   .NCH       (NCH),
   .CHW       (CHW),
   .MAX_BURST (MAX_BURST)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_en   (cfg_en),
   .cfg_chan (cfg_chan),
   .fifo_rd  (fifo_rd),
   .bus_sel  (bus_sel),
   .blast_n  (blast_n),
   .rd_ready (rd_ready),
   .last_v   (st_v[NSTAGE-1])
);

// File: tb/burst_prefetch_pipe_bench.sv
module burst_prefetch_pipe_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 4;
   localparam int DW         = 32;
   localparam int NSTAGE     = 3;
   localparam int MAX_BURST  = 256;
   localparam int CHW        = 2;
   localparam int NOLAST     = 100000;

   // columns: burst length, idle cycles before it, expected cycle of first ready
   localparam int TBL_N = 6;
   localparam int TBL [TBL_N][3] = '{
      '{1, 1, 0}, '{4, 3, 0}, '{16, 1, 0}, '{2, 5, 0}, '{9, 2, 0}, '{30, 1, 0}
   };

   logic              clk;
   logic              rst_n;
   logic              cfg_en;
   logic [CHW-1:0]    cfg_chan;
   logic [NCH-1:0]    fifo_empty;
   logic [NCH*DW-1:0] fifo_data;
   logic [NCH-1:0]    fifo_rd;
   logic              bus_sel;
   logic              blast_n;
   logic              rd_ready;
   logic [DW-1:0]     rd_data;

   int favail [NCH];
   int fseq   [NCH];
   int ppop   [NCH];
   int exp_seq[NCH];

   int n_chk;
   int n_fail;
   bit done;
   int g_beats, g_first, g_gaps, g_ling;

   burst_prefetch_pipe #(
      .NCH(NCH), .DW(DW), .NSTAGE(NSTAGE), .MAX_BURST(MAX_BURST)
   ) u_burst_prefetch_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_en     (cfg_en),
      .cfg_chan   (cfg_chan),
      .fifo_empty (fifo_empty),
      .fifo_data  (fifo_data),
      .fifo_rd    (fifo_rd),
      .bus_sel    (bus_sel),
      .blast_n    (blast_n),
      .rd_ready   (rd_ready),
      .rd_data    (rd_data)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // show-ahead FIFO model: word n of channel c reads as {c, n}
   always_comb begin
      for (int c = 0; c < NCH; c++) begin
         fifo_empty[c]          = (favail[c] == 0);
         fifo_data[c*DW +: DW]  = {8'(c), 24'(fseq[c])};
      end
   end

   always @(posedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (fifo_rd[c]) begin
            fseq[c]   <= fseq[c] + 1;
            favail[c] <= favail[c] - 1;
            ppop[c]   <= ppop[c] + 1;
         end
      end
   end

   task automatic chk_eq(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d (0x%08h) expected=%0d (0x%08h)", what, act, act, exp, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         bus_sel = 1'b0;
         blast_n = 1'b1;
      end
   endtask

   task automatic do_burst(input int len, input int linger, input int limit,
                           input int refill_at, input int sw_chan);
      int cyc;
      g_beats = 0; g_first = -1; g_gaps = 0; g_ling = 0; cyc = 0;
      while (g_beats < len && cyc < limit) begin
         @(negedge clk);
         if (cyc == refill_at) favail[cfg_chan] = 4000;
         if (cyc == 0 && sw_chan >= 0) cfg_chan = CHW'(sw_chan);
         bus_sel = 1'b1;
         blast_n = (g_beats == len - 1) ? 1'b0 : 1'b1;
         #1;
         if (rd_ready) begin
            chk_eq("R4 R6 R8 beat data in order", int'(rd_data),
                   int'({8'(cfg_chan), 24'(exp_seq[cfg_chan])}));
            exp_seq[cfg_chan]++;
            if (g_first < 0) g_first = cyc;
            g_beats++;
         end else if (g_first >= 0) begin
            g_gaps++;
         end
         cyc++;
      end
      repeat (linger) begin
         @(negedge clk);
         bus_sel = 1'b1;
         blast_n = 1'b1;
         #1;
         if (rd_ready) g_ling++;
      end
      @(negedge clk);
      bus_sel = 1'b0;
      blast_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int p0;
      n_chk = 0; n_fail = 0; done = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         favail[c] = 0; fseq[c] = 0; ppop[c] = 0; exp_seq[c] = 0;
      end
      favail[0] = 4000;
      rst_n = 1'b0; cfg_en = 1'b0; cfg_chan = '0; bus_sel = 1'b1; blast_n = 1'b1;

      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      chk_eq("R1 ready low in reset", int'(rd_ready), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk_eq("R1 ready low after reset", int'(rd_ready), 0);

      // R2: accesses ignored while disabled
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         chk_eq("R2 no ready while disabled", int'(rd_ready), 0);
         chk_eq("R2 no pop while disabled", int'(fifo_rd), 0);
      end
      idle(1);
      chk_eq("R1 R2 nothing popped before enable", ppop[0], 0);

      cfg_en = 1'b1;
      idle(2);

      // R3: cold start, R4 continuous advance
      do_burst(8, 0, 100, -1, -1);
      chk_eq("R3 cold first ready cycle", g_first, NSTAGE + 1);
      chk_eq("R4 cold burst beats", g_beats, 8);
      chk_eq("R4 no gaps once streaming", g_gaps, 0);
      idle(6);
      chk_eq("R11 pops equal beats plus depth", ppop[0], 8 + NSTAGE);

      // R6 warm restarts, R4 per-clock advance, from the table
      for (int t = 0; t < TBL_N; t++) begin
         idle(TBL[t][1]);
         do_burst(TBL[t][0], 0, TBL[t][0] + 20, -1, -1);
         chk_eq("R6 warm first ready cycle", g_first, TBL[t][2]);
         chk_eq("R4 warm beats", g_beats, TBL[t][0]);
         chk_eq("R4 warm no gaps", g_gaps, 0);
      end

      // R7: FIFO runs dry mid-burst, then refills at cycle 8
      idle(2);
      favail[0] = 0;
      idle(2);
      do_burst(6, 0, 50, 8, -1);
      chk_eq("R7 first ready from kept words", g_first, 0);
      chk_eq("R7 stall cycles", g_gaps, 8);
      chk_eq("R7 beats after refill", g_beats, 6);

      // R5: access held past its last beat
      idle(2);
      do_burst(3, 3, 20, -1, -1);
      chk_eq("R5 beats before last", g_beats, 3);
      chk_eq("R5 ready after last beat", g_ling, 0);

      // R10: access that never marks a last beat
      idle(2);
      do_burst(NOLAST, 0, MAX_BURST + 4, -1, -1);
      chk_eq("R10 beats in limited burst", g_beats, MAX_BURST);
      chk_eq("R10 ready low past limit", g_gaps, 4);

      // R9 R8: switch channel while idle
      idle(2);
      favail[1] = 50;
      p0 = ppop[0];
      cfg_chan = 2'd1;
      idle(5);
      chk_eq("R8 old channel not popped after switch", ppop[0], p0);
      chk_eq("R8 new channel not popped before access", ppop[1], 0);
      do_burst(5, 0, 40, -1, -1);
      chk_eq("R9 cold latency after switch", g_first, NSTAGE + 1);
      chk_eq("R9 beats on new channel", g_beats, 5);
      idle(5);
      chk_eq("R11 new channel pops", ppop[1], 5 + NSTAGE);
      chk_eq("R8 old channel untouched", ppop[0], p0);

      // R9: switch in the first cycle of an access
      exp_seq[0] = fseq[0];
      do_burst(4, 0, 40, -1, 0);
      chk_eq("R9 latency with switch in access", g_first, NSTAGE + 2);
      chk_eq("R9 beats after switch", g_beats, 4);

      // R9: disable flushes the kept words
      idle(2);
      cfg_en = 1'b0;
      idle(3);
      cfg_en = 1'b1;
      exp_seq[0] = fseq[0];
      idle(1);
      do_burst(4, 0, 40, -1, -1);
      chk_eq("R9 cold latency after disable", g_first, NSTAGE + 1);
      chk_eq("R9 beats after disable", g_beats, 4);

      idle(3);
      finish_run();
   end

endmodule